// File: doc/BRIEF.md
# Three-Level Neutral-Clamped Gate Pulse Generator

This block turns a space-vector choice into gate pulses for a three-phase, three-level neutral-point-clamped leg set. Each switching period it takes a sector number, a sub-triangle number and three dwell times. From these it picks three phase-state vectors. Every vector is one of the 27 combinations of P, O and N per phase. It plays them in a symmetric seven-segment pattern timed by a period counter, and it drives four gates per phase.

Each phase moves one level at a time. Every change of level is guarded by a programmable dead time. During that time both switches of the affected complementary pair are held off. A write port with a two-bit address sets the period length and the dead time. A one-cycle overflow pulse marks the last count of every period. New selections are taken only at that boundary.

Top module: `npc_gate_gen`

## Requirements
- R1: Gate nibble per phase is {S1,S2,S3,S4}; phase a is on bits 3:0, b on 7:4 and c on 11:8. Level P drives 1100, O drives 0110 and N drives 0011. After reset every phase is at O, so gate_o = 12'h666, and ovf_o is low.
- R2: The period counter runs from 0 to PERIOD-1 and then wraps. ovf_o is high exactly in the cycle the counter holds PERIOD-1. PERIOD is at address 0 and resets to 10000, which gives 10 kHz at a 100 MHz tick. A written value below 2 is stored as 2.
- R3: The dead time D is at address 1 and resets to 600. On a one-level step, the pair that changes is held low for D cycles, starting in the cycle after the target changes, and then the new level appears. The pair is S1/S3 for P↔O and S2/S4 for O↔N. During that hold the phase shows 0100 or 0010. With D = 0 the new level appears in the cycle after the target changes.
- R4: A phase never moves directly between P and N. It steps to O first, and each step carries its own dead time.
- R5: Within a period the slots run A,B,C,A,C,B,A. Their lengths are t0/4, t1/2, t2/2, t0/2, t2/2 and t1/2, with floor division, and the last A slot fills the rest of the period. The phase target is registered from the counter value, so gates start to move two clock edges after the counter first shows a value in a new slot.
- R6: Codes use 2 = P, 1 = O, 0 = N, listed as (a,b,c). In sector 0 the vectors are:
  - sub-triangle 0: A=111, B=211, C=221
  - sub-triangle 1: A=211, B=200, C=210
  - sub-triangle 2: A=211, B=210, C=221
  - sub-triangle 3: A=221, B=210, C=220
- R7: Each sector step rotates a vector by (a,b,c) → (2-b, 2-c, 2-a). Sector s applies this rotation s mod 6 times, so sector 6 behaves as sector 0 and sector 7 as sector 1.
- R8: Sector, sub-triangle and dwell inputs are sampled only in the cycle ovf_o is high, and they govern the next period. Changes at other times have no effect.
- R9: A write happens only with cfg_we_i high. Addresses 2 and 3 change nothing.
- R10: S1 and S3 are never both high, and neither are S2 and S4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Time-base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Register address (0 period, 1 dead time) |
| cfg_wdata_i | input | 16 | Write data |
| sector_i | input | 3 | Sector number |
| subtri_i | input | 2 | Sub-triangle number within the sector |
| t0_i | input | 16 | Dwell of the A vector, in ticks |
| t1_i | input | 16 | Dwell of the B vector, in ticks |
| t2_i | input | 16 | Dwell of the C vector, in ticks |
| gate_o | output | 12 | Gate drives, four per phase |
| ovf_o | output | 1 | High in the last count of each period |

## Verification
Two functions can fall in the same cycle: the period boundary, which latches a new selection and raises ovf_o, and a phase still counting out its dead time or halfway through a P-to-N detour through O. The bench provokes this overlap in two ways. It sets the dead time longer than the first slot. It also flips between sectors whose A vectors lie on opposite levels, so a phase must reverse across the wrap. A behavioural model steps alongside the design every clock and judges each gate nibble and the overflow pulse. Separate per-cycle monitors catch pair overlap and direct P/N jumps.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef logic [1:0] lvl_t;  // 0 N, 1 O, 2 P
  localparam lvl_t LV_N = 2'd0;
  localparam lvl_t LV_O = 2'd1;
  localparam lvl_t LV_P = 2'd2;
  typedef lvl_t [2:0] vec_t;  // [0] phase a
  localparam int NUM_STATES = 27;

  function automatic vec_t mk_vec(lvl_t a, lvl_t b, lvl_t c);
    vec_t v;
    v[0] = a; v[1] = b; v[2] = c;
    return v;
  endfunction

  function automatic vec_t rot60(vec_t v);
    vec_t r;
    r[0] = lvl_t'(2'd2 - v[1]);
    r[1] = lvl_t'(2'd2 - v[2]);
    r[2] = lvl_t'(2'd2 - v[0]);
    return r;
  endfunction

  // sector-0 vectors, slot 0 = A, 1 = B, 2 = C
  function automatic vec_t base_vec(logic [1:0] tri_n, logic [1:0] slot);
    case ({tri_n, slot})
      4'b00_00: return mk_vec(LV_O, LV_O, LV_O);
      4'b00_01: return mk_vec(LV_P, LV_O, LV_O);
      4'b00_10: return mk_vec(LV_P, LV_P, LV_O);
      4'b01_00: return mk_vec(LV_P, LV_O, LV_O);
      4'b01_01: return mk_vec(LV_P, LV_N, LV_N);
      4'b01_10: return mk_vec(LV_P, LV_O, LV_N);
      4'b10_00: return mk_vec(LV_P, LV_O, LV_O);
      4'b10_01: return mk_vec(LV_P, LV_O, LV_N);
      4'b10_10: return mk_vec(LV_P, LV_P, LV_O);
      4'b11_00: return mk_vec(LV_P, LV_P, LV_O);
      4'b11_01: return mk_vec(LV_P, LV_O, LV_N);
      4'b11_10: return mk_vec(LV_P, LV_P, LV_N);
      default:  return mk_vec(LV_O, LV_O, LV_O);
    endcase
  endfunction

  function automatic vec_t pick_vec(logic [2:0] sec, logic [1:0] tri_n, logic [1:0] slot);
    vec_t v;
    v = base_vec(tri_n, slot);
    for (int i = 0; i < 7; i++)
      if (i < int'(sec)) v = rot60(v);
    return v;
  endfunction

  function automatic logic [3:0] gate_enc(lvl_t l);
    case (l)
      LV_P:    return 4'b1100;
      LV_N:    return 4'b0011;
      default: return 4'b0110;
    endcase
  endfunction
endpackage

// File: rtl/npc_cfg_regs.sv
module npc_cfg_regs #(
  parameter int TW = 16,
  parameter int PER_RST = 10000,
  parameter int DEAD_RST = 600
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [TW-1:0] wdata_i,
  output logic [TW-1:0] per_o,
  output logic [TW-1:0] dead_o
);
  localparam logic [TW-1:0] PER_MIN = TW'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_o  <= TW'(PER_RST);
      dead_o <= TW'(DEAD_RST);
    end else if (we_i) begin
      case (addr_i)
        2'd0: per_o  <= (wdata_i < PER_MIN) ? PER_MIN : wdata_i;
        2'd1: dead_o <= wdata_i;
        default: ;
      endcase
    end
  end

  a_r2_per_min: assert property (@(posedge clk_i) disable iff (!rst_ni) per_o >= PER_MIN);
endmodule

// File: rtl/npc_timebase.sv
module npc_timebase #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] per_i,
  output logic [TW-1:0] cnt_o,
  output logic          wrap_o
);
  assign wrap_o = cnt_o >= per_i - TW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (wrap_o) cnt_o <= '0;
    else             cnt_o <= cnt_o + TW'(1);
  end

  a_r2_ovf_single: assert property (@(posedge clk_i) disable iff (!rst_ni) wrap_o |=> !wrap_o);
  a_r2_wrap_zero:  assert property (@(posedge clk_i) disable iff (!rst_ni) wrap_o |=> cnt_o == '0);
endmodule

// File: rtl/npc_seq.sv
module npc_seq
  import npc_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wrap_i,
  input  logic [TW-1:0] cnt_i,
  input  logic [2:0]    sector_i,
  input  logic [1:0]    subtri_i,
  input  logic [TW-1:0] t0_i,
  input  logic [TW-1:0] t1_i,
  input  logic [TW-1:0] t2_i,
  output vec_t          tgt_o
);
  localparam int CW = TW + 3;

  logic [2:0]    sec_q;
  logic [1:0]    tri_q;
  logic [TW-1:0] t0_q, t1_q, t2_q;
  logic [CW-1:0] e0, e1, e2, e3, e4, e5, c;
  logic [1:0]    slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0; tri_q <= '0; t0_q <= '0; t1_q <= '0; t2_q <= '0;
    end else if (wrap_i) begin
      sec_q <= sector_i; tri_q <= subtri_i;
      t0_q <= t0_i; t1_q <= t1_i; t2_q <= t2_i;
    end
  end

  always_comb begin
    c  = CW'(cnt_i);
    e0 = CW'(t0_q >> 2);
    e1 = e0 + CW'(t1_q >> 1);
    e2 = e1 + CW'(t2_q >> 1);
    e3 = e2 + CW'(t0_q >> 1);
    e4 = e3 + CW'(t2_q >> 1);
    e5 = e4 + CW'(t1_q >> 1);
    if      (c < e0) slot = 2'd0;
    else if (c < e1) slot = 2'd1;
    else if (c < e2) slot = 2'd2;
    else if (c < e3) slot = 2'd0;
    else if (c < e4) slot = 2'd2;
    else if (c < e5) slot = 2'd1;
    else             slot = 2'd0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tgt_o <= mk_vec(LV_O, LV_O, LV_O);
    else         tgt_o <= pick_vec(sec_q, tri_q, slot);
  end

  a_r8_hold_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> ($stable(sec_q) && $stable(tri_q) && $stable(t0_q) && $stable(t1_q) && $stable(t2_q)));
endmodule

// File: rtl/npc_phase_leg.sv
module npc_phase_leg
  import npc_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  lvl_t          tgt_i,
  input  logic [TW-1:0] dead_i,
  output logic [3:0]    gate_o
);
  lvl_t          cur_q, nxt_q, step;
  logic          busy_q;
  logic [TW-1:0] dt_q;
  logic          upper;

  assign step  = (tgt_i > cur_q) ? lvl_t'(cur_q + 2'd1) : lvl_t'(cur_q - 2'd1);
  assign upper = (cur_q == LV_P) || (nxt_q == LV_P);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= LV_O; nxt_q <= LV_O; busy_q <= 1'b0; dt_q <= '0;
    end else if (busy_q) begin
      if (dt_q == '0) begin
        busy_q <= 1'b0;
        cur_q  <= nxt_q;
      end else begin
        dt_q <= dt_q - TW'(1);
      end
    end else if (tgt_i != cur_q) begin
      if (dead_i == '0) begin
        cur_q <= step;
      end else begin
        busy_q <= 1'b1;
        nxt_q  <= step;
        dt_q   <= dead_i - TW'(1);
      end
    end
  end

  // hold the changing complementary pair off during dead time
  always_comb begin
    gate_o = gate_enc(cur_q);
    if (busy_q) begin
      if (upper) begin gate_o[3] = 1'b0; gate_o[1] = 1'b0; end
      else       begin gate_o[2] = 1'b0; gate_o[0] = 1'b0; end
    end
  end

  a_r10_pair_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_o[3] && gate_o[1]) && !(gate_o[2] && gate_o[0]));
  a_r4_no_p_to_n: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q == LV_P) |=> (cur_q != LV_N));
  a_r4_no_n_to_p: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q == LV_N) |=> (cur_q != LV_P));
  a_r3_dead_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && dt_q != '0) |=> (busy_q && $stable(cur_q)));
endmodule

// File: rtl/npc_gate_gen.sv
module npc_gate_gen
  import npc_pkg::*;
#(
  parameter int TW = 16,
  parameter int PER_RST = 10000,
  parameter int DEAD_RST = 600
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_addr_i,
  input  logic [TW-1:0] cfg_wdata_i,
  input  logic [2:0]    sector_i,
  input  logic [1:0]    subtri_i,
  input  logic [TW-1:0] t0_i,
  input  logic [TW-1:0] t1_i,
  input  logic [TW-1:0] t2_i,
  output logic [11:0]   gate_o,
  output logic          ovf_o
);
  logic [TW-1:0] per, dead, cnt;
  vec_t          tgt;

  npc_cfg_regs #(.TW(TW), .PER_RST(PER_RST), .DEAD_RST(DEAD_RST)) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .per_o(per), .dead_o(dead)
  );

  npc_timebase #(.TW(TW)) u_tb (
    .clk_i, .rst_ni, .per_i(per), .cnt_o(cnt), .wrap_o(ovf_o)
  );

  npc_seq #(.TW(TW)) u_seq (
    .clk_i, .rst_ni, .wrap_i(ovf_o), .cnt_i(cnt), .sector_i, .subtri_i,
    .t0_i, .t1_i, .t2_i, .tgt_o(tgt)
  );

  for (genvar p = 0; p < 3; p++) begin : g_leg
    npc_phase_leg #(.TW(TW)) u_leg (
      .clk_i, .rst_ni, .tgt_i(tgt[p]), .dead_i(dead), .gate_o(gate_o[4*p +: 4])
    );
  end
endmodule

// File: tb/npc_gate_gen_bench.sv
`timescale 1ns/1ps
module npc_gate_gen_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [2:0]  sector = '0;
  logic [1:0]  subtri = '0;
  logic [15:0] t0 = '0, t1 = '0, t2 = '0;
  logic [11:0] gate;
  logic        ovf;

  int checks = 0, failures = 0;
  bit run = 1'b0, done = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  npc_gate_gen u_npc_gate_gen (
    .clk_i(clk), .rst_ni, .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .sector_i(sector), .subtri_i(subtri), .t0_i(t0), .t1_i(t1), .t2_i(t2),
    .gate_o(gate), .ovf_o(ovf)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_cnt, m_per, m_dead, m_sec, m_tri, m_t0, m_t1, m_t2;
  int m_tgt[3], m_cur[3], m_nxt[3], m_dt[3];
  bit m_busy[3];

  function automatic int lvl_of(int sec, int tri_n, int slot, int ph);
    int code, a, b, c, na, nb, nc;
    case (tri_n * 3 + slot)
      0: code = 111;  1: code = 211;  2: code = 221;
      3: code = 211;  4: code = 200;  5: code = 210;
      6: code = 211;  7: code = 210;  8: code = 221;
      9: code = 221; 10: code = 210; 11: code = 220;
      default: code = 111;
    endcase
    a = code / 100; b = (code / 10) % 10; c = code % 10;
    for (int k = 0; k < sec % 6; k++) begin
      na = 2 - b; nb = 2 - c; nc = 2 - a;
      a = na; b = nb; c = nc;
    end
    return (ph == 0) ? a : (ph == 1) ? b : c;
  endfunction

  function automatic int slot_of(int cnt);
    int d[7];
    int sl[7];
    int acc;
    d[0] = m_t0 / 4; d[1] = m_t1 / 2; d[2] = m_t2 / 2; d[3] = m_t0 / 2;
    d[4] = m_t2 / 2; d[5] = m_t1 / 2; d[6] = 0;
    sl[0] = 0; sl[1] = 1; sl[2] = 2; sl[3] = 0; sl[4] = 2; sl[5] = 1; sl[6] = 0;
    acc = 0;
    for (int k = 0; k < 6; k++) begin
      acc += d[k];
      if (cnt < acc) return sl[k];
    end
    return 0;
  endfunction

  function automatic int enc(int l);
    return (l == 2) ? 'hC : (l == 0) ? 'h3 : 'h6;
  endfunction

  function automatic int exp_gate(int ph);
    int g;
    g = enc(m_cur[ph]);
    if (m_busy[ph]) begin
      if (m_cur[ph] == 2 || m_nxt[ph] == 2) g = g & 'h5 & ~'hA | (g & 'h4);
      else g = g & 'hA;
    end
    return g;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_per = 10000; m_dead = 600;
      m_sec = 0; m_tri = 0; m_t0 = 0; m_t1 = 0; m_t2 = 0;
      for (int p = 0; p < 3; p++) begin
        m_tgt[p] = 1; m_cur[p] = 1; m_nxt[p] = 1; m_dt[p] = 0; m_busy[p] = 0;
      end
    end else begin
      int sl;
      bit wrap;
      for (int p = 0; p < 3; p++) begin
        if (m_busy[p]) begin
          if (m_dt[p] == 0) begin m_busy[p] = 0; m_cur[p] = m_nxt[p]; end
          else m_dt[p]--;
        end else if (m_tgt[p] != m_cur[p]) begin
          int st;
          st = (m_tgt[p] > m_cur[p]) ? m_cur[p] + 1 : m_cur[p] - 1;
          if (m_dead == 0) m_cur[p] = st;
          else begin m_busy[p] = 1; m_nxt[p] = st; m_dt[p] = m_dead - 1; end
        end
      end
      sl = slot_of(m_cnt);
      for (int p = 0; p < 3; p++) m_tgt[p] = lvl_of(m_sec, m_tri, sl, p);
      wrap = (m_cnt >= m_per - 1);
      if (wrap) begin
        m_sec = int'(sector); m_tri = int'(subtri);
        m_t0 = int'(t0); m_t1 = int'(t1); m_t2 = int'(t2);
        m_cnt = 0;
      end else m_cnt++;
      if (cfg_we) begin
        if (cfg_addr == 2'd0) m_per = (cfg_wdata < 2) ? 2 : int'(cfg_wdata);
        else if (cfg_addr == 2'd1) m_dead = int'(cfg_wdata);
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  logic [3:0] prev_g [3];
  always @(negedge clk) begin
    if (rst_ni && run) begin
      for (int p = 0; p < 3; p++) begin
        logic [3:0] g;
        g = gate[4*p +: 4];
        chk({cur_req, " gates"}, int'(g), exp_gate(p));
        chk("R10 pair overlap", int'((g[3] & g[1]) | (g[2] & g[0])), 0);
        chk("R4 direct P/N", int'((prev_g[p] == 4'b1100 && g == 4'b0011) ||
                                  (prev_g[p] == 4'b0011 && g == 4'b1100)), 0);
        prev_g[p] = g;
      end
      chk("R2 ovf", int'(ovf), int'(m_cnt >= m_per - 1));
    end
  end

  task automatic wr(logic we, logic [1:0] a, int d);
    @(negedge clk);
    cfg_we = we; cfg_addr = a; cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic sel(int s, int tr, int a, int b, int c);
    sector = 3'(s); subtri = 2'(tr); t0 = 16'(a); t1 = 16'(b); t2 = 16'(c);
  endtask

  initial begin
    for (int p = 0; p < 3; p++) prev_g[p] = 4'b0110;
    repeat (4) @(negedge clk);
    chk("R1 reset gates", int'(gate), 'h666);
    chk("R1 reset ovf", int'(ovf), 0);
    rst_ni = 1'b1;
    run = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'(gate), 'h666);

    // R2: default period
    begin
      int n;
      n = 0;
      while (!ovf && n < 20000) begin @(negedge clk); n++; end
      @(negedge clk);
      n = 1;
      while (!ovf && n < 20000) begin @(negedge clk); n++; end
      chk("R2 default period", n, 10000);
    end

    wr(1'b1, 2'd0, 200);
    wr(1'b1, 2'd1, 3);

    cur_req = "R6";
    for (int tr = 0; tr < 4; tr++) begin
      sel(0, tr, 80, 60, 60);
      repeat (600) @(negedge clk);
    end

    cur_req = "R7";
    for (int s = 1; s < 8; s++) begin
      sel(s, s % 4, 60, 70, 70);
      repeat (400) @(negedge clk);
    end

    cur_req = "R5";
    sel(2, 2, 41, 33, 27); repeat (400) @(negedge clk);
    sel(4, 1, 0, 150, 50); repeat (400) @(negedge clk);
    sel(5, 3, 20, 20, 20); repeat (400) @(negedge clk);

    cur_req = "R3";
    wr(1'b1, 2'd1, 0);
    sel(1, 1, 80, 60, 60); repeat (400) @(negedge clk);
    wr(1'b1, 2'd1, 40);
    sel(3, 3, 40, 10, 150); repeat (600) @(negedge clk);
    wr(1'b1, 2'd1, 3);

    cur_req = "R4";
    for (int k = 0; k < 4; k++) begin
      sel((k % 2) * 3, 1, 60, 80, 60);
      repeat (230) @(negedge clk);
    end
    wr(1'b1, 2'd1, 25);
    for (int k = 0; k < 4; k++) begin
      sel((k % 2) * 3, 3, 20, 100, 80);
      repeat (260) @(negedge clk);
    end
    wr(1'b1, 2'd1, 3);

    cur_req = "R8";
    for (int k = 0; k < 30; k++) begin
      sel(k % 6, (k * 3) % 4, 20 + k, 90 - k, 40 + 2 * k);
      repeat (37) @(negedge clk);
    end
    repeat (400) @(negedge clk);

    cur_req = "R9";
    sel(0, 2, 60, 70, 70);
    wr(1'b0, 2'd0, 50);
    wr(1'b1, 2'd2, 50);
    wr(1'b1, 2'd3, 0);
    repeat (500) @(negedge clk);

    cur_req = "R2";
    wr(1'b1, 2'd0, 1);
    repeat (20) @(negedge clk);
    wr(1'b1, 2'd0, 200);
    repeat (400) @(negedge clk);

    run = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule